// File: doc/BRIEF.md
# SDRAM Power-Down and Clock-Enable Controller

This block owns the clock-enable (CKE) line of an SDRAM interface. While the interface sits idle with automatic power-down switched on, it counts a programmed number of idle cycles and then drops CKE. The memory then falls into active power-down if a row is still open, or precharge power-down if every bank is closed. When a command reaches the command FIFO, CKE comes back at once. The next command is held back until the programmed exit delay has elapsed.

A command-permit output tells the command path when it may issue. The block also runs the self-refresh sequence on request. It keeps CKE low for at least the minimum self-refresh residency, and it holds the command path off for the self-refresh exit delay after leaving. A strap sampled during reset tells the block that the memory was left in self-refresh while the rest of the controller lost power. In that case the block comes up in the self-refresh state and reports low-power status, not configuration status.

The states are CONFIG, READY, ACT_PD, PRE_PD, PD_EXIT, SR_ENTER, SR and SR_EXIT. The transitions are:
- CONFIG→READY when configuration completes.
- READY→ACT_PD or READY→PRE_PD when the idle count expires.
- READY→SR_ENTER on a self-refresh request.
- ACT_PD or PRE_PD→PD_EXIT when the command FIFO is non-empty.
- PD_EXIT→READY when the tXP delay ends.
- SR_ENTER→SR when the tESR delay ends.
- SR→SR_EXIT on an exit request.
- SR_EXIT→READY when the tXSR delay ends.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: While reset is held with `pwrup_sr` low, the state is CONFIG (code 0), status is 0, `cke` is 1 and `cmd_ok` is 1. A clock edge with `cfg_done` high moves CONFIG to READY (code 1).
- R2: The interface is idle when `cmd_fifo_empty`, `rd_fifo_empty` and `cmd_dly_done` are all high. In READY, with `auto_pd_en` high and `idle_period` = P > 0, the state leaves READY for power-down on the P-th consecutive clock edge at which the interface is idle.
- R3: Any clock edge in READY at which the interface is not idle restarts the idle count from zero.
- R4: Power-down entry goes to ACT_PD (code 2) if `row_open` is high at the entry edge, and to PRE_PD (code 3) otherwise.
- R5: With `auto_pd_en` low, or with `idle_period` equal to 0, the state never leaves READY for a power-down state.
- R6: In ACT_PD or PRE_PD, a clock edge with `cmd_fifo_empty` low moves to PD_EXIT (code 4), and `cke` is high from that edge on.
- R7: PD_EXIT lasts max(`t_xp`,1) cycles with `cmd_ok` low, then returns to READY.
- R8: In READY, a clock edge with `sr_req` high moves to SR_ENTER (code 5), and `sr_req` takes priority over power-down entry. SR_ENTER lasts max(`t_esr`,1) cycles, during which `sr_exit_req` is ignored, and then moves to SR (code 6).
- R9: In SR, a clock edge with `sr_exit_req` high moves to SR_EXIT (code 7) with `cke` high. SR_EXIT lasts max(`t_xsr`,1) cycles and then returns to READY.
- R10: `cke` is low in codes 2, 3, 5 and 6 and high in all other states. `cmd_ok` is high only in CONFIG and READY.
- R11: If `pwrup_sr` is high while reset is held, the state is SR (code 6), `cke` is 0 and status is 2, and the state stays in SR after reset is released.
- R12: Status (`pd_status`) is 0 in CONFIG, 2 (low-power) in codes 2, 3, 5 and 6, and 1 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwrup_sr | input | 1 | Strap: memory was retained in self-refresh across the reset |
| cfg_done | input | 1 | Configuration finished; leave CONFIG |
| auto_pd_en | input | 1 | Enables automatic power-down |
| idle_period | input | IW | Idle cycles before power-down (0 disables) |
| t_xp | input | TW | Power-down exit delay in cycles |
| t_esr | input | TW | Minimum self-refresh residency in cycles |
| t_xsr | input | TW | Self-refresh exit delay in cycles |
| cmd_fifo_empty | input | 1 | Command FIFO is empty |
| rd_fifo_empty | input | 1 | Read-data FIFO is empty |
| cmd_dly_done | input | 1 | Last inter-command delay has expired |
| row_open | input | 1 | At least one row is open |
| sr_req | input | 1 | Request self-refresh entry |
| sr_exit_req | input | 1 | Request self-refresh exit |
| cke | output | 1 | Clock enable to the memory |
| cmd_ok | output | 1 | Command path may issue |
| pd_state | output | 3 | Current state code |
| pd_status | output | 2 | 0 config, 1 active, 2 low-power |

## Verification
The bench builds the block with a 4-bit idle-period field and 3-bit delay fields. These widths keep every count short enough that each timer runs through its full expiry within a few cycles. It programs an idle period of 3 and delays of 2, 2 and 3, which makes it possible to break an idle count partway through and to observe the boundary between a delay that is still running and one that is done. It also programs an idle period of 1 and a tXP of 0, to cover the shortest power-down entry and the single-cycle exit.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;

    typedef enum logic [2:0] {
        ST_CONFIG   = 3'd0,
        ST_READY    = 3'd1,
        ST_ACT_PD   = 3'd2,
        ST_PRE_PD   = 3'd3,
        ST_PD_EXIT  = 3'd4,
        ST_SR_ENTER = 3'd5,
        ST_SR       = 3'd6,
        ST_SR_EXIT  = 3'd7
    } pd_state_e;

    typedef enum logic [1:0] {
        STS_CONFIG    = 2'd0,
        STS_ACTIVE    = 2'd1,
        STS_LOW_POWER = 2'd2
    } pd_status_e;

endpackage

// File: rtl/pd_idle_timer.sv
module pd_idle_timer #(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          idle,
    input  logic          arm,
    input  logic [IW-1:0] period,
    output logic          expired
);
    logic [IW-1:0] cnt_q;

    // Count consecutive idle edges in READY; any break clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || !idle || !arm) begin
            cnt_q <= '0;
        end else if (cnt_q != period) begin
            cnt_q <= cnt_q + IW'(1);
        end
    end

    always_comb begin
        expired = run && idle && arm && (period != '0) &&
                  (cnt_q == period - IW'(1));
    end

endmodule

// File: rtl/pd_delay_timer.sv
module pd_delay_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    // Done on the last cycle of the window; a value of 0 behaves as 1.
    always_comb begin
        done = (cnt_q <= TW'(1));
    end

endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import sdram_pd_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwrup_sr,
    input  logic          cfg_done,
    input  logic          pd_expired,
    input  logic          cmd_fifo_empty,
    input  logic          row_open,
    input  logic          sr_req,
    input  logic          sr_exit_req,
    input  logic          dly_done,
    input  logic [TW-1:0] t_xp,
    input  logic [TW-1:0] t_esr,
    input  logic [TW-1:0] t_xsr,
    output pd_state_e     state,
    output logic          dly_load,
    output logic [TW-1:0] dly_val,
    output logic          timer_run,
    output logic          cke,
    output logic          cmd_ok,
    output pd_status_e    status
);
    pd_state_e state_q;
    pd_state_e state_d;

    // State register: the reset target depends on the retention strap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= pwrup_sr ? ST_SR : ST_CONFIG;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONFIG:   if (cfg_done) state_d = ST_READY;
            ST_READY: begin
                if (sr_req)          state_d = ST_SR_ENTER;
                else if (pd_expired) state_d = row_open ? ST_ACT_PD : ST_PRE_PD;
            end
            ST_ACT_PD,
            ST_PRE_PD:   if (!cmd_fifo_empty) state_d = ST_PD_EXIT;
            ST_PD_EXIT:  if (dly_done) state_d = ST_READY;
            ST_SR_ENTER: if (dly_done) state_d = ST_SR;
            ST_SR:       if (sr_exit_req) state_d = ST_SR_EXIT;
            ST_SR_EXIT:  if (dly_done) state_d = ST_READY;
            default:     state_d = ST_CONFIG;
        endcase
    end

    // One shared delay counter, loaded on entry to any timed state.
    always_comb begin
        dly_load = 1'b0;
        dly_val  = '0;
        if (state_d != state_q) begin
            unique case (state_d)
                ST_PD_EXIT:  begin dly_load = 1'b1; dly_val = t_xp;  end
                ST_SR_ENTER: begin dly_load = 1'b1; dly_val = t_esr; end
                ST_SR_EXIT:  begin dly_load = 1'b1; dly_val = t_xsr; end
                default:     begin dly_load = 1'b0; dly_val = '0;    end
            endcase
        end
    end

    // Output decode from the registered state.
    always_comb begin
        state     = state_q;
        timer_run = (state_q == ST_READY);
        cke       = 1'b1;
        cmd_ok    = 1'b0;
        status    = STS_ACTIVE;
        unique case (state_q)
            ST_CONFIG:   begin cmd_ok = 1'b1; status = STS_CONFIG; end
            ST_READY:    begin cmd_ok = 1'b1; end
            ST_ACT_PD,
            ST_PRE_PD,
            ST_SR_ENTER,
            ST_SR:       begin cke = 1'b0; status = STS_LOW_POWER; end
            ST_PD_EXIT,
            ST_SR_EXIT:  begin cke = 1'b1; end
            default:     begin cke = 1'b1; end
        endcase
    end

    assert_act_pd_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACT_PD && $past(state_q) == ST_READY) |-> $past(row_open));

    assert_pre_pd_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE_PD && $past(state_q) == ST_READY) |-> !$past(row_open));

    assert_wake_on_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ACT_PD || state_q == ST_PRE_PD) && !cmd_fifo_empty)
        |=> (state_q == ST_PD_EXIT && cke));

    assert_xp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PD_EXIT && !dly_done) |=> (state_q == ST_PD_EXIT && !cmd_ok));

    assert_esr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SR_ENTER && !dly_done) |=> state_q == ST_SR_ENTER);

    assert_sr_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SR && sr_exit_req) |=> (state_q == ST_SR_EXIT && cke));

endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
    import sdram_pd_pkg::*;
#(
    parameter int IW = 8,
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwrup_sr,
    input  logic          cfg_done,
    input  logic          auto_pd_en,
    input  logic [IW-1:0] idle_period,
    input  logic [TW-1:0] t_xp,
    input  logic [TW-1:0] t_esr,
    input  logic [TW-1:0] t_xsr,
    input  logic          cmd_fifo_empty,
    input  logic          rd_fifo_empty,
    input  logic          cmd_dly_done,
    input  logic          row_open,
    input  logic          sr_req,
    input  logic          sr_exit_req,
    output logic          cke,
    output logic          cmd_ok,
    output logic [2:0]    pd_state,
    output logic [1:0]    pd_status
);
    logic          idle;
    logic          pd_expired;
    logic          timer_run;
    logic          dly_load;
    logic [TW-1:0] dly_val;
    logic          dly_done;
    pd_state_e     fsm_state;
    pd_status_e    fsm_status;

    assign idle      = cmd_fifo_empty && rd_fifo_empty && cmd_dly_done;
    assign pd_state  = fsm_state;
    assign pd_status = fsm_status;

    pd_idle_timer #(.IW(IW)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .idle    (idle),
        .arm     (auto_pd_en),
        .period  (idle_period),
        .expired (pd_expired)
    );

    pd_delay_timer #(.TW(TW)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .done     (dly_done)
    );

    pd_fsm #(.TW(TW)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwrup_sr       (pwrup_sr),
        .cfg_done       (cfg_done),
        .pd_expired     (pd_expired),
        .cmd_fifo_empty (cmd_fifo_empty),
        .row_open       (row_open),
        .sr_req         (sr_req),
        .sr_exit_req    (sr_exit_req),
        .dly_done       (dly_done),
        .t_xp           (t_xp),
        .t_esr          (t_esr),
        .t_xsr          (t_xsr),
        .state          (fsm_state),
        .dly_load       (dly_load),
        .dly_val        (dly_val),
        .timer_run      (timer_run),
        .cke            (cke),
        .cmd_ok         (cmd_ok),
        .status         (fsm_status)
    );

    assert_pd_needs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_state == ST_ACT_PD || fsm_state == ST_PRE_PD) && $past(fsm_state) == ST_READY)
        |-> $past(idle && auto_pd_en && idle_period != '0));

    assert_no_pd_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_READY && (!auto_pd_en || idle_period == '0))
        |=> (fsm_state != ST_ACT_PD && fsm_state != ST_PRE_PD));

endmodule

// File: tb/sdram_pd_ctrl_test.sv
module sdram_pd_ctrl_test;
    localparam int IW = 4;
    localparam int TW = 3;
    localparam int NV = 25;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pwrup_sr, cfg_done, auto_pd_en;
    logic [IW-1:0] idle_period;
    logic [TW-1:0] t_xp, t_esr, t_xsr;
    logic          cmd_fifo_empty, rd_fifo_empty, cmd_dly_done, row_open;
    logic          sr_req, sr_exit_req;
    logic          cke, cmd_ok;
    logic [2:0]    pd_state;
    logic [1:0]    pd_status;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    sdram_pd_ctrl #(.IW(IW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .pwrup_sr(pwrup_sr), .cfg_done(cfg_done),
        .auto_pd_en(auto_pd_en), .idle_period(idle_period),
        .t_xp(t_xp), .t_esr(t_esr), .t_xsr(t_xsr),
        .cmd_fifo_empty(cmd_fifo_empty), .rd_fifo_empty(rd_fifo_empty),
        .cmd_dly_done(cmd_dly_done), .row_open(row_open),
        .sr_req(sr_req), .sr_exit_req(sr_exit_req),
        .cke(cke), .cmd_ok(cmd_ok), .pd_state(pd_state), .pd_status(pd_status)
    );

    // Row fields: cfg, cmd_empty, rd_empty, dly_done, row_open, sr_req, sr_exit,
    // expected state[2:0], expected cke, expected cmd_ok.
    localparam logic [11:0] VEC [NV] = '{
        12'b1_0_1_1_0_0_0_001_1_1, // R1 leave CONFIG
        12'b0_1_1_1_0_0_0_001_1_1, // R2 idle 1
        12'b0_1_1_1_0_0_0_001_1_1, // R2 idle 2
        12'b0_1_1_1_0_0_0_011_0_0, // R2 R4 third idle edge, no row -> PRE_PD
        12'b0_1_1_1_0_0_0_011_0_0, // R10 stays down
        12'b0_0_1_1_0_0_0_100_1_0, // R6 wake
        12'b0_0_1_1_0_0_0_100_1_0, // R7 tXP running
        12'b0_0_1_1_0_0_0_001_1_1, // R7 back to READY
        12'b0_1_1_1_0_0_0_001_1_1, // R3 idle 1
        12'b0_1_1_1_0_0_0_001_1_1, // R3 idle 2
        12'b0_1_0_1_0_0_0_001_1_1, // R3 read data pending
        12'b0_1_1_1_0_0_0_001_1_1, // R3 restarted 1
        12'b0_1_1_1_0_0_0_001_1_1, // R3 restarted 2
        12'b0_1_1_1_1_0_0_010_0_0, // R4 row open -> ACT_PD
        12'b0_0_1_1_1_0_0_100_1_0, // R6 wake
        12'b0_0_1_1_0_0_0_100_1_0, // R7
        12'b0_0_1_1_0_0_0_001_1_1, // R7
        12'b0_0_1_1_0_1_0_101_0_0, // R8 enter
        12'b0_0_1_1_0_0_1_101_0_0, // R8 exit request ignored
        12'b0_0_1_1_0_0_0_110_0_0, // R8 in SR
        12'b0_0_1_1_0_0_0_110_0_0, // R9 stays
        12'b0_0_1_1_0_0_1_111_1_0, // R9 exit
        12'b0_0_1_1_0_0_0_111_1_0, // R9 tXSR 2
        12'b0_0_1_1_0_0_0_111_1_0, // R9 tXSR 3
        12'b0_0_1_1_0_0_0_001_1_1  // R9 back to READY
    };

    function automatic int exp_status(input int st);
        if (st == 0) return 0;
        if (st == 2 || st == 3 || st == 5 || st == 6) return 2;
        return 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input int st, input int k, input int ok);
        check({req, " state"}, int'(pd_state), st);
        check({req, " cke"}, int'(cke), k);
        check({req, " cmd_ok"}, int'(cmd_ok), ok);
        check({req, " R12 status"}, int'(pd_status), exp_status(st));
    endtask

    task automatic set_idle();
        cmd_fifo_empty = 1'b1; rd_fifo_empty = 1'b1; cmd_dly_done = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pwrup_sr = 1'b0; cfg_done = 1'b0; auto_pd_en = 1'b1;
        idle_period = 4'd3; t_xp = 3'd2; t_esr = 3'd2; t_xsr = 3'd3;
        cmd_fifo_empty = 1'b0; rd_fifo_empty = 1'b1; cmd_dly_done = 1'b1;
        row_open = 1'b0; sr_req = 1'b0; sr_exit_req = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 reset", 0, 1, 1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cfg_done       = VEC[i][11];
            cmd_fifo_empty = VEC[i][10];
            rd_fifo_empty  = VEC[i][9];
            cmd_dly_done   = VEC[i][8];
            row_open       = VEC[i][7];
            sr_req         = VEC[i][6];
            sr_exit_req    = VEC[i][5];
            @(negedge clk);
            check_all($sformatf("R10 vec%0d", i), int'(VEC[i][4:2]),
                      int'(VEC[i][1]), int'(VEC[i][0]));
        end

        // R5: auto power-down switched off
        auto_pd_en = 1'b0; set_idle();
        repeat (6) @(negedge clk);
        check_all("R5 disabled", 1, 1, 1);
        // R5: zero idle period
        auto_pd_en = 1'b1; idle_period = '0;
        repeat (6) @(negedge clk);
        check_all("R5 zero period", 1, 1, 1);
        // R2 boundary: period 1 enters on the first idle edge
        idle_period = 4'd1; t_xp = 3'd0;
        @(negedge clk);
        check_all("R2 period one", 3, 0, 0);
        // R7 boundary: tXP of 0 gives a single exit cycle
        cmd_fifo_empty = 1'b0;
        @(negedge clk);
        check_all("R6 wake", 4, 1, 0);
        @(negedge clk);
        check_all("R7 zero txp", 1, 1, 1);

        // R8 priority: self-refresh request beats an expiring idle count
        set_idle(); sr_req = 1'b1;
        @(negedge clk);
        check_all("R8 priority", 5, 0, 0);
        sr_req = 1'b0;

        // R11: retained self-refresh across reset
        rst_n = 1'b0; pwrup_sr = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R11 in reset", 6, 0, 0);
        rst_n = 1'b1; pwrup_sr = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R11 after reset", 6, 0, 0);
        sr_exit_req = 1'b1;
        @(negedge clk);
        check_all("R9 exit retained", 7, 1, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule